// File: doc/BRIEF.md
# Double-Buffered Monochrome Framebuffer Arbiter

This block keeps two monochrome pixel stores of 64 columns by 32 rows. Drawing logic works only on the working store, through a port that writes single pixels and reads them back in the same cycle for exclusive-or sprite updates. Video scan-out reads only the display store, through a registered port that the arbiter never stalls.

Sprites are removed by drawing them a second time over the same pixels. If scan-out showed the working store directly, half-erased sprites would flicker. The arbiter therefore copies the working store into the display store only at quiet moments. A quiet moment is a few processor ticks after the latest draw event. A forced copy also runs after a longer run of ticks since the previous copy, so a program that never stops drawing still reaches the screen. A copy moves one full row per clock and takes one clock per row.

A synchronous clear wipes the working store in one clock and counts as a draw event. The display store keeps its contents until the next copy.

Top module: `fbArbiter`

## Requirements
- R1: A write with `wrEn` high sets the working pixel at column `wkX`, row `wkY` to `wrData` at the next clock edge and leaves every other pixel unchanged. `wkRdData` shows the working pixel at (`wkX`, `wkY`) combinationally in the same cycle.
- R2: `dispPix` is registered: it shows the display pixel at the `dispX`/`dispY` presented in the previous cycle. Writes to the working store do not change the display store until a copy runs. While no copy runs and the address is held, `dispPix` holds its value.
- R3: With no copy running, a copy starts on the clock edge that samples the `QUIET_TICKS`-th (default 4) `cpuTick` since the latest draw event, where a draw event is `drawStrobe` or `clear`. A draw event in the same cycle as a tick restarts the count at zero. Each quiet period starts at most one copy.
- R4: With no copy running, a copy starts on the clock edge that samples the `MAX_TICKS`-th (default 10) `cpuTick` since the previous copy started. This happens even when draw events keep arriving.
- R5: A copy moves row r of the working store into the display store at the (r+1)-th clock edge after the start edge. It runs for exactly `ROWS` clocks, rows in ascending order.
- R6: A trigger that arrives while a copy runs is dropped. It neither restarts nor extends the copy, and it is not replayed after the copy ends.
- R7: `clear` zeroes every working pixel at the next clock edge and counts as a draw event. It does not touch the display store.
- R8: After reset both stores are all zero, both tick counts are zero and no copy is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wkX | input | 6 | Working port column |
| wkY | input | 5 | Working port row |
| wrData | input | 1 | Pixel value to write |
| wrEn | input | 1 | Working pixel write enable |
| wkRdData | output | 1 | Working pixel at (wkX, wkY), combinational |
| drawStrobe | input | 1 | Draw activity pulse |
| cpuTick | input | 1 | One pulse per processor cycle |
| clear | input | 1 | Zero the working store (counts as a draw event) |
| dispX | input | 6 | Display read column |
| dispY | input | 5 | Display read row |
| dispPix | output | 1 | Registered display pixel |

## Verification
The hardest case to reach from the ports is a trigger that lands while a copy is already running, because copies are short and triggers depend on tick history. The bench starts a quiet-period copy and then fires a tick every clock, so the forced-copy count expires in the middle of the copy. During the same copy it writes a working pixel in a row that has already been copied. That pixel must never reach the display. The bench also measures the copy length exactly: it watches a pixel in the last row and checks that the pixel changes on the registered port only one clock after the last row edge.

// File: rtl/fbArbPkg.sv
package fbArbPkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic copyEn;     // move one row from working to display this cycle
    logic clearWork;  // zero the working store
  } fbStrb_t;
endpackage

// File: rtl/fbArbCtrl.sv
module fbArbCtrl
  import fbArbPkg::*;
#(
  parameter int ROWS        = 32,
  parameter int QUIET_TICKS = 4,
  parameter int MAX_TICKS   = 10,
  localparam int YW = $clog2(ROWS),
  localparam int QW = $clog2(QUIET_TICKS + 1),
  localparam int MW = $clog2(MAX_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          drawStrobe,
  input  logic          clear,
  input  logic          cpuTick,
  output fbStrb_t       strb,
  output logic [YW-1:0] copyRow,
  output logic          copyBusy
);
  logic [QW-1:0] sinceDraw;
  logic [MW-1:0] sinceCopy;
  logic          drawEvt, quietFire, maxFire, startCopy;

  assign drawEvt   = drawStrobe | clear;
  // fire only on the transition into the limit; counters saturate there
  assign quietFire = cpuTick && !drawEvt && (sinceDraw == QW'(QUIET_TICKS - 1));
  assign maxFire   = cpuTick && (sinceCopy == MW'(MAX_TICKS - 1));
  assign startCopy = (quietFire || maxFire) && !copyBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceDraw <= '0;
    end else if (drawEvt) begin
      sinceDraw <= '0;
    end else if (cpuTick && sinceDraw != QW'(QUIET_TICKS)) begin
      sinceDraw <= sinceDraw + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceCopy <= '0;
    end else if (startCopy) begin
      sinceCopy <= '0;
    end else if (cpuTick && sinceCopy != MW'(MAX_TICKS)) begin
      sinceCopy <= sinceCopy + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      copyBusy <= 1'b0;
      copyRow  <= '0;
    end else if (startCopy) begin
      copyBusy <= 1'b1;
      copyRow  <= '0;
    end else if (copyBusy) begin
      copyRow <= copyRow + 1'b1;
      if (copyRow == YW'(ROWS - 1)) copyBusy <= 1'b0;
    end
  end

  always_comb begin
    strb.copyEn    = copyBusy;
    strb.clearWork = clear;
  end
endmodule

// File: rtl/fbArbData.sv
module fbArbData
  import fbArbPkg::*;
#(
  parameter int COLS = 64,
  parameter int ROWS = 32,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fbStrb_t       strb,
  input  logic [YW-1:0] copyRow,
  input  logic [XW-1:0] wkX,
  input  logic [YW-1:0] wkY,
  input  logic          wrData,
  input  logic          wrEn,
  output logic          wkRdData,
  input  logic [XW-1:0] dispX,
  input  logic [YW-1:0] dispY,
  output logic          dispPix
);
  logic [COLS-1:0] workMem [ROWS];
  logic [COLS-1:0] dispMem [ROWS];

  // working store: clear has priority over a pixel write
  always_ff @(posedge clk) begin
    if (!rstN || strb.clearWork) begin
      for (int r = 0; r < ROWS; r++) workMem[r] <= '0;
    end else if (wrEn) begin
      workMem[wkY][wkX] <= wrData;
    end
  end

  assign wkRdData = workMem[wkY][wkX];

  // display store: written only by the row-wide copy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) dispMem[r] <= '0;
    end else if (strb.copyEn) begin
      dispMem[copyRow] <= workMem[copyRow];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dispPix <= 1'b0;
    else       dispPix <= dispMem[dispY][dispX];
  end
endmodule

// File: rtl/fbArbiter.sv
module fbArbiter
  import fbArbPkg::*;
#(
  parameter int COLS        = 64,
  parameter int ROWS        = 32,
  parameter int QUIET_TICKS = 4,
  parameter int MAX_TICKS   = 10,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [XW-1:0] wkX,
  input  logic [YW-1:0] wkY,
  input  logic          wrData,
  input  logic          wrEn,
  output logic          wkRdData,
  input  logic          drawStrobe,
  input  logic          cpuTick,
  input  logic          clear,
  input  logic [XW-1:0] dispX,
  input  logic [YW-1:0] dispY,
  output logic          dispPix
);
  fbStrb_t       strb;
  logic [YW-1:0] copyRow;
  logic          copyBusy;

  fbArbCtrl #(.ROWS(ROWS), .QUIET_TICKS(QUIET_TICKS), .MAX_TICKS(MAX_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .drawStrobe(drawStrobe), .clear(clear),
    .cpuTick(cpuTick), .strb(strb), .copyRow(copyRow), .copyBusy(copyBusy)
  );

  fbArbData #(.COLS(COLS), .ROWS(ROWS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .copyRow(copyRow),
    .wkX(wkX), .wkY(wkY), .wrData(wrData), .wrEn(wrEn), .wkRdData(wkRdData),
    .dispX(dispX), .dispY(dispY), .dispPix(dispPix)
  );
endmodule

// File: rtl/fbArbChk.sv
module fbArbChk #(
  parameter int ROWS = 32,
  parameter int XW   = 6,
  parameter int YW   = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuTick,
  input logic          clear,
  input logic          copyBusy,
  input logic [XW-1:0] dispX,
  input logic [YW-1:0] dispY,
  input logic          dispPix,
  input logic          wkRdData
);
  logic [15:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)         busyCnt <= '0;
    else if (copyBusy) busyCnt <= busyCnt + 16'd1;
    else               busyCnt <= '0;
  end

  // R3 / R4: a copy only begins on a sampled tick
  p_start_on_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(copyBusy) |-> $past(cpuTick));

  // R5: every copy lasts exactly ROWS clocks
  p_copy_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(copyBusy) |-> (busyCnt == 16'(ROWS)));

  // R6: a trigger during a copy never stretches it
  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= 16'(ROWS));

  // R2: idle display with a held address keeps its output
  p_disp_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !copyBusy && !$past(copyBusy) && $stable(dispX) && $stable(dispY))
      |=> $stable(dispPix));

  // R7: after a clear every working pixel reads zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (wkRdData == 1'b0));
endmodule

bind fbArbiter fbArbChk #(.ROWS(ROWS), .XW(XW), .YW(YW)) uChk (
  .clk(clk), .rstN(rstN), .cpuTick(cpuTick), .clear(clear),
  .copyBusy(copyBusy), .dispX(dispX), .dispY(dispY),
  .dispPix(dispPix), .wkRdData(wkRdData)
);

// File: tb/tb_fbArbiter.sv
module tb_fbArbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] wkX = '0;
  logic [4:0] wkY = '0;
  logic       wrData = 1'b0, wrEn = 1'b0, drawStrobe = 1'b0, cpuTick = 1'b0, clear = 1'b0;
  logic [5:0] dispX = '0;
  logic [4:0] dispY = '0;
  logic       wkRdData, dispPix;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  fbArbiter dut (
    .clk(clk), .rstN(rstN), .wkX(wkX), .wkY(wkY), .wrData(wrData), .wrEn(wrEn),
    .wkRdData(wkRdData), .drawStrobe(drawStrobe), .cpuTick(cpuTick), .clear(clear),
    .dispX(dispX), .dispY(dispY), .dispPix(dispPix)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit got, input bit exp, input string req);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putPix(input int x, input int y, input bit v, input bit strobe);
    @(negedge clk);
    wkX = 6'(x); wkY = 5'(y); wrData = v; wrEn = 1'b1; drawStrobe = strobe;
    @(negedge clk);
    wrEn = 1'b0; drawStrobe = 1'b0;
  endtask

  task automatic pulseDraw();
    @(negedge clk); drawStrobe = 1'b1;
    @(negedge clk); drawStrobe = 1'b0;
  endtask

  task automatic tick(input int settle);
    @(negedge clk); cpuTick = 1'b1;
    @(negedge clk); cpuTick = 1'b0;
    waitCyc(settle);
  endtask

  task automatic getWork(input int x, input int y, output bit v);
    @(negedge clk); wkX = 6'(x); wkY = 5'(y);
    #1 v = wkRdData;
  endtask

  task automatic getDisp(input int x, input int y, output bit v);
    @(negedge clk); dispX = 6'(x); dispY = 5'(y);
    @(negedge clk); v = dispPix;
  endtask

  // R8: everything zero after reset
  task automatic tReset();
    bit v;
    getDisp(10, 3, v); check(v, 1'b0, "R8 display zero");
    getWork(63, 31, v); check(v, 1'b0, "R8 working zero");
  endtask

  // R1, R2: working writes and read-back; display untouched
  task automatic tWorkPort();
    bit v;
    putPix(3, 2, 1'b1, 1'b1);
    putPix(4, 2, 1'b1, 1'b1);
    putPix(4, 2, 1'b0, 1'b1);
    getWork(3, 2, v); check(v, 1'b1, "R1 pixel set");
    getWork(4, 2, v); check(v, 1'b0, "R1 pixel overwritten");
    getWork(3, 3, v); check(v, 1'b0, "R1 neighbour untouched");
    getDisp(3, 2, v); check(v, 1'b0, "R2 display not yet copied");
  endtask

  // R3: quiet-period copy on the 4th tick after a draw
  task automatic tQuiet();
    bit v;
    for (int i = 1; i <= 3; i++) tick(40);
    getDisp(3, 2, v); check(v, 1'b0, "R3 no copy after 3 ticks");
    tick(40);
    getDisp(3, 2, v); check(v, 1'b1, "R3 copy after 4th tick");
  endtask

  // R3: a fresh draw event restarts the quiet count
  task automatic tQuietRestart();
    bit v;
    putPix(7, 9, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) tick(40);
    pulseDraw();
    for (int i = 0; i < 3; i++) tick(40);
    getDisp(7, 9, v); check(v, 1'b0, "R3 restarted count holds copy");
    tick(40);
    getDisp(7, 9, v); check(v, 1'b1, "R3 copy after restarted quiet");
  endtask

  // R4: forced copy on the 10th tick while drawing continues
  task automatic tForced();
    bit v;
    putPix(5, 5, 1'b1, 1'b1);
    for (int i = 1; i <= 9; i++) begin
      pulseDraw();
      tick(40);
    end
    getDisp(5, 5, v); check(v, 1'b0, "R4 no copy before 10th tick");
    pulseDraw();
    tick(40);
    getDisp(5, 5, v); check(v, 1'b1, "R4 forced copy on 10th tick");
  endtask

  // R5: last row lands exactly ROWS edges after the start edge
  task automatic tTiming();
    putPix(63, 31, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) tick(40);
    @(negedge clk); dispX = 6'd63; dispY = 5'd31; cpuTick = 1'b1;
    @(posedge clk);                 // start edge
    @(negedge clk); cpuTick = 1'b0;
    repeat (32) @(posedge clk);     // last row written on the 32nd edge
    @(negedge clk); check(dispPix, 1'b0, "R5 last row not visible yet");
    @(negedge clk); check(dispPix, 1'b1, "R5 last row visible one clock later");
  endtask

  // R6: triggers inside a copy are dropped
  task automatic tIgnore();
    bit v;
    pulseDraw();
    for (int i = 0; i < 3; i++) tick(40);
    tick(0);                        // quiet copy starts here
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cpuTick = 1'b1;
      if (i == 5) begin
        wkX = 6'd0; wkY = 5'd0; wrData = 1'b1; wrEn = 1'b1;
      end else begin
        wrEn = 1'b0;
      end
    end
    @(negedge clk); cpuTick = 1'b0; wrEn = 1'b0;
    waitCyc(80);
    getWork(0, 0, v); check(v, 1'b1, "R6 working pixel written");
    getDisp(0, 0, v); check(v, 1'b0, "R6 forced trigger in copy dropped");
    for (int i = 0; i < 3; i++) tick(40);
    getDisp(0, 0, v); check(v, 1'b0, "R6 dropped trigger not replayed");
  endtask

  // R7: clear wipes working only and counts as a draw event
  task automatic tClear();
    bit v;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    getWork(5, 5, v); check(v, 1'b0, "R7 working cleared");
    getWork(0, 0, v); check(v, 1'b0, "R7 working cleared row 0");
    getDisp(63, 31, v); check(v, 1'b1, "R7 display kept after clear");
    for (int i = 0; i < 3; i++) tick(40);
    getDisp(63, 31, v); check(v, 1'b1, "R7 clear restarted quiet count");
    tick(40);
    getDisp(63, 31, v); check(v, 1'b0, "R7 cleared store copied");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tWorkPort();
    tQuiet();
    tQuietRestart();
    tForced();
    tTiming();
    tIgnore();
    tClear();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule